// File: doc/BRIEF.md
# Address-Filtering Serial Receiver for a Shared Line

This block receives asynchronous serial frames on a line that several nodes share. Each frame has a low start bit, eight data bits sent least-significant bit first, one extra address-flag bit, and a high stop bit. The line rests high between frames. A frame whose flag bit is 1 names a node. A frame whose flag bit is 0 carries payload for the node that was named last.

The receiver holds a node number on an input. It stays deaf until an address frame arrives, then compares that frame's byte with the node number. On a hit it becomes the listening node and passes the payload frames that follow to the host. On a miss it goes deaf again until the next address frame. Accepted bytes land in a data register, with a ready flag and a one-cycle receive interrupt. A stop bit that reads low sets an error flag and gives a one-cycle error interrupt. Payload that arrives while the ready flag is still up sets an overrun flag and is dropped. A single acknowledge input clears the flags.

The line is oversampled at sixteen ticks per bit, and one tick lasts a fixed number of clocks. A start bit counts only if the line is still low half a bit after the falling edge. Every later bit is read at its centre.

Top module: `mpr_uart_rx`

## Requirements
- R1: Data bits are taken least-significant first. Each bit is read at its centre, sixteen ticks after the previous read, and the first read falls eight ticks after the falling edge. The flags and the data register change on the clock edge that comes 3 + 168·DIV_CLKS cycles after the edge that registered the first low line sample.
- R2: After a synchronous reset, every output is 0 and the node is not listening.
- R3: While the node is not listening, frames with flag bit 0 change no output.
- R4: An address frame (flag bit 1) whose byte equals `node_id_i` makes the node listen. That address byte is never delivered and sets no flag.
- R5: While the node is listening, a payload frame (flag bit 0) with a good stop bit loads its byte into `rx_data_o`, sets `data_ready_o`, and pulses `rx_irq_o` high for exactly one cycle.
- R6: An address frame whose byte differs from `node_id_i` stops the node listening, whether or not it was listening before. Payload frames after it change no output.
- R7: A frame whose stop bit reads low sets `frame_err_o` and pulses `err_irq_o` for one cycle. It changes neither the listening state nor `rx_data_o`, even when it is an address frame that matches.
- R8: A payload byte accepted while `data_ready_o` is 1 sets `overrun_o`. The older byte stays in `rx_data_o`, and no `rx_irq_o` pulse occurs.
- R9: `ack_i` high for one cycle clears `data_ready_o`, `overrun_o` and `frame_err_o` on the next edge. A byte that is accepted in that same cycle is stored as new.
- R10: A low pulse shorter than half a bit is rejected as a false start. It changes no output, and a proper frame after it is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial line, idle high |
| node_id_i | input | 8 | This node's number |
| ack_i | input | 1 | Host acknowledge; clears the flags |
| rx_data_o | output | 8 | Last accepted payload byte |
| data_ready_o | output | 1 | An unread byte is waiting |
| overrun_o | output | 1 | A byte was dropped because the flag was still up |
| frame_err_o | output | 1 | A stop bit was read low |
| rx_irq_o | output | 1 | One-cycle pulse when a byte is accepted |
| err_irq_o | output | 1 | One-cycle pulse on a framing error |

## Verification
The listening state has no port of its own, so a wrong state shows up only when the next payload frame finishes. That frame is either delivered when it should be dropped, or dropped when it should be delivered, and the difference appears on `data_ready_o` and `rx_irq_o` at the stop-bit centre. A sampling phase that is off by a tick or more shifts bits, or moves the flag update away from its fixed cycle. The comparison on every cycle catches that on the first frame. A stuck or missing interrupt pulse is seen in the single cycle after the flag update.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    localparam int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_WAITHI
    } samp_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mp;
        logic              stop;
    } frame_t;

    function automatic logic frame_is_addr(frame_t f);
        return f.mp;
    endfunction

    function automatic logic frame_hits(frame_t f, logic [DATA_W-1:0] id);
        return f.mp && (f.data == id);
    endfunction

endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) sr_q <= '1;
        else       sr_q <= {sr_q[STAGES-2:0], d_i};
    end

    assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mpr_sampler.sv
module mpr_sampler
    import mpr_pkg::*;
#(
    parameter int unsigned DIV_CLKS   = 27,
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   rx_s_i,
    output logic   frm_valid_o,
    output frame_t frm_o
);
    localparam int unsigned DIV_W  = (DIV_CLKS > 1) ? $clog2(DIV_CLKS) : 1;
    localparam int unsigned TCNT_W = $clog2(OVERSAMPLE);
    localparam int unsigned BIT_W  = $clog2(DATA_W + 2);
    localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(DIV_CLKS - 1);
    localparam logic [TCNT_W-1:0] T_MID    = TCNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [TCNT_W-1:0] T_LAST   = TCNT_W'(OVERSAMPLE - 1);
    localparam logic [BIT_W-1:0]  MP_IDX   = BIT_W'(DATA_W);

    samp_state_e       state_q;
    logic [DIV_W-1:0]  div_q;
    logic [TCNT_W-1:0] tcnt_q;
    logic [BIT_W-1:0]  bidx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              mp_q;
    logic              frm_valid_q;
    frame_t            frm_q;
    logic              running;
    logic              tick;

    always_comb begin
        running = (state_q == ST_START) || (state_q == ST_BITS);
        tick    = running && (div_q == DIV_LAST);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q     <= ST_IDLE;
            div_q       <= '0;
            tcnt_q      <= '0;
            bidx_q      <= '0;
            shreg_q     <= '0;
            mp_q        <= 1'b0;
            frm_valid_q <= 1'b0;
            frm_q       <= '0;
        end else begin
            frm_valid_q <= 1'b0;
            if (running && !tick) div_q <= div_q + 1'b1;
            else                  div_q <= '0;
            if (tick) begin
                if (tcnt_q == T_LAST) tcnt_q <= '0;
                else                  tcnt_q <= tcnt_q + 1'b1;
            end
            case (state_q)
                ST_IDLE: begin
                    if (!rx_s_i) begin
                        state_q <= ST_START;
                        tcnt_q  <= '0;
                    end
                end
                ST_START: begin
                    if (tick && tcnt_q == T_MID) begin
                        tcnt_q <= '0;
                        bidx_q <= '0;
                        state_q <= rx_s_i ? ST_IDLE : ST_BITS;
                    end
                end
                ST_BITS: begin
                    if (tick && tcnt_q == T_LAST) begin
                        if (bidx_q < MP_IDX) begin
                            shreg_q <= {rx_s_i, shreg_q[DATA_W-1:1]};
                            bidx_q  <= bidx_q + 1'b1;
                        end else if (bidx_q == MP_IDX) begin
                            mp_q   <= rx_s_i;
                            bidx_q <= bidx_q + 1'b1;
                        end else begin
                            frm_valid_q <= 1'b1;
                            frm_q       <= '{data: shreg_q, mp: mp_q, stop: rx_s_i};
                            state_q     <= rx_s_i ? ST_IDLE : ST_WAITHI;
                        end
                    end
                end
                default: begin
                    if (rx_s_i) state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign frm_valid_o = frm_valid_q;
    assign frm_o       = frm_q;

    // R1: a finished frame is reported for one cycle only
    assert_frame_single_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        frm_valid_q |=> !frm_valid_q);

    // R10: a frame can only finish from the bit-reading phase
    assert_frame_from_bits_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        frm_valid_q |-> $past(state_q) == ST_BITS);
endmodule

// File: rtl/mpr_filter.sv
module mpr_filter
    import mpr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              frm_valid_i,
    input  frame_t            frm_i,
    input  logic [DATA_W-1:0] node_id_i,
    input  logic              ack_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdy_o,
    output logic              ovr_o,
    output logic              ferr_o,
    output logic              rx_irq_o,
    output logic              err_irq_o
);
    logic              sel_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rdy_q, ovr_q, ferr_q, rx_irq_q, err_irq_q;
    logic              good, bad, deliver, busy;

    always_comb begin
        good    = frm_valid_i && frm_i.stop;
        bad     = frm_valid_i && !frm_i.stop;
        deliver = good && !frame_is_addr(frm_i) && sel_q;
        busy    = rdy_q && !ack_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sel_q     <= 1'b0;
            rdata_q   <= '0;
            rdy_q     <= 1'b0;
            ovr_q     <= 1'b0;
            ferr_q    <= 1'b0;
            rx_irq_q  <= 1'b0;
            err_irq_q <= 1'b0;
        end else begin
            rx_irq_q  <= 1'b0;
            err_irq_q <= 1'b0;
            if (ack_i) begin
                rdy_q  <= 1'b0;
                ovr_q  <= 1'b0;
                ferr_q <= 1'b0;
            end
            if (bad) begin
                ferr_q    <= 1'b1;
                err_irq_q <= 1'b1;
            end
            if (good && frame_is_addr(frm_i)) sel_q <= frame_hits(frm_i, node_id_i);
            if (deliver) begin
                if (busy) begin
                    ovr_q <= 1'b1;
                end else begin
                    rdata_q  <= frm_i.data;
                    rdy_q    <= 1'b1;
                    rx_irq_q <= 1'b1;
                end
            end
        end
    end

    assign rdata_o   = rdata_q;
    assign rdy_o     = rdy_q;
    assign ovr_o     = ovr_q;
    assign ferr_o    = ferr_q;
    assign rx_irq_o  = rx_irq_q;
    assign err_irq_o = err_irq_q;

    // R5: the ready flag never rises without its interrupt pulse
    assert_ready_has_irq_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rdy_q) |-> rx_irq_q);

    // R3: no delivery follows a cycle in which the node was not listening
    assert_deaf_is_silent_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !sel_q |=> !rx_irq_q);

    // R8: an unacknowledged byte is never overwritten
    assert_byte_kept_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (rdy_q && !ack_i) |=> $stable(rdata_q));

    // R8: overrun only exists alongside a waiting byte
    assert_overrun_with_ready_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        ovr_q |-> rdy_q);

    // R7: the error pulse comes with the error flag, never with a delivery
    assert_err_pulse_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        err_irq_q |-> ferr_q && !rx_irq_q);

    // R9: acknowledge without a new frame leaves the flags clear
    assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (ack_i && !frm_valid_i) |=> !rdy_q && !ovr_q && !ferr_q);
endmodule

// File: rtl/mpr_uart_rx.sv
module mpr_uart_rx
    import mpr_pkg::*;
#(
    parameter int unsigned DIV_CLKS    = 27,
    parameter int unsigned OVERSAMPLE  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rx_i,
    input  logic [DATA_W-1:0] node_id_i,
    input  logic              ack_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              data_ready_o,
    output logic              overrun_o,
    output logic              frame_err_o,
    output logic              rx_irq_o,
    output logic              err_irq_o
);
    logic   rx_s;
    logic   frm_valid;
    frame_t frm;

    mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (rx_i),
        .q_o   (rx_s)
    );

    mpr_sampler #(.DIV_CLKS(DIV_CLKS), .OVERSAMPLE(OVERSAMPLE)) u_sampler (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .rx_s_i      (rx_s),
        .frm_valid_o (frm_valid),
        .frm_o       (frm)
    );

    mpr_filter u_filter (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .frm_valid_i (frm_valid),
        .frm_i       (frm),
        .node_id_i   (node_id_i),
        .ack_i       (ack_i),
        .rdata_o     (rx_data_o),
        .rdy_o       (data_ready_o),
        .ovr_o       (overrun_o),
        .ferr_o      (frame_err_o),
        .rx_irq_o    (rx_irq_o),
        .err_irq_o   (err_irq_o)
    );
endmodule

// File: tb/mpr_uart_rx_tb.sv
module mpr_uart_rx_tb_top;
    localparam int DIV  = 2;
    localparam int BITC = 16 * DIV;
    localparam int UPD  = 3 + 168 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic [7:0] node_id = 8'hA7;
    logic       ack = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready, overrun, frame_err, rx_irq, err_irq;

    always #10 clk = ~clk;

    mpr_uart_rx #(.DIV_CLKS(DIV)) dut_i (
        .clk_i(clk), .rst_i(rst), .rx_i(rx), .node_id_i(node_id), .ack_i(ack),
        .rx_data_o(rx_data), .data_ready_o(data_ready), .overrun_o(overrun),
        .frame_err_o(frame_err), .rx_irq_o(rx_irq), .err_irq_o(err_irq)
    );

    // behavioural model state
    logic [7:0] m_data = 8'h00;
    logic m_rdy = 0, m_ovr = 0, m_ferr = 0, m_rxirq = 0, m_errirq = 0;
    bit   m_sel = 0;
    bit   checking = 0;
    bit   done = 0;
    int   n_cmp = 0, n_bad = 0;
    string cur_req = "R2";

    task automatic cmp1(string name, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            cmp1("rx_data", rx_data, m_data);
            cmp1("data_ready", data_ready, m_rdy);
            cmp1("overrun", overrun, m_ovr);
            cmp1("frame_err", frame_err, m_ferr);
            cmp1("rx_irq", rx_irq, m_rxirq);
            cmp1("err_irq", err_irq, m_errirq);
        end
    end

    task automatic model_frame(logic [7:0] b, logic mp, logic stop_ok);
        if (!stop_ok) begin
            m_ferr = 1; m_errirq = 1;
        end else if (mp) begin
            m_sel = (b == node_id);
        end else if (m_sel) begin
            if (m_rdy) m_ovr = 1;
            else begin m_data = b; m_rdy = 1; m_rxirq = 1; end
        end
    endtask

    task automatic send_frame(string req, logic [7:0] b, logic mp, logic stop_ok);
        logic [10:0] bits;
        cur_req = req;
        bits = {stop_ok, mp, b, 1'b0};
        for (int c = 0; c < 11 * BITC; c++) begin
            @(negedge clk);
            rx = bits[c / BITC];
            @(posedge clk);
            if (c == UPD) model_frame(b, mp, stop_ok);
            if (c == UPD + 1) begin m_rxirq = 0; m_errirq = 0; end
        end
        @(negedge clk);
        rx = 1'b1;
        repeat (BITC) @(posedge clk);
    endtask

    task automatic do_ack(string req);
        cur_req = req;
        @(negedge clk);
        ack = 1'b1;
        @(posedge clk);
        m_rdy = 0; m_ovr = 0; m_ferr = 0;
        @(negedge clk);
        ack = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic glitch(string req);
        cur_req = req;
        @(negedge clk);
        rx = 1'b0;
        repeat (4 * DIV) @(negedge clk);
        rx = 1'b1;
        repeat (2 * BITC) @(posedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checking = 1;
        repeat (20) @(posedge clk);                  // R2 reset state
        send_frame("R3", 8'h5A, 1'b0, 1'b1);         // deaf: payload ignored
        send_frame("R6", 8'h33, 1'b1, 1'b1);         // address miss
        send_frame("R6", 8'h11, 1'b0, 1'b1);
        send_frame("R4", 8'hA7, 1'b1, 1'b1);         // address hit, not delivered
        send_frame("R5", 8'h3C, 1'b0, 1'b1);
        send_frame("R8", 8'hC5, 1'b0, 1'b1);         // overrun keeps 3C
        do_ack("R9");
        send_frame("R1", 8'h81, 1'b0, 1'b1);         // bit order check
        do_ack("R9");
        send_frame("R7", 8'h00, 1'b1, 1'b0);         // bad stop, mismatching address
        send_frame("R7", 8'hFF, 1'b0, 1'b1);         // still listening
        do_ack("R9");
        glitch("R10");
        send_frame("R10", 8'h00, 1'b0, 1'b1);
        do_ack("R9");
        send_frame("R6", 8'h12, 1'b1, 1'b0 | 1'b1);  // deselect after listening
        send_frame("R6", 8'h77, 1'b0, 1'b1);
        send_frame("R7", 8'hA7, 1'b1, 1'b0);         // matching but bad stop: no select
        send_frame("R7", 8'h44, 1'b0, 1'b1);
        do_ack("R9");
        send_frame("R4", 8'hA7, 1'b1, 1'b1);
        send_frame("R1", 8'h96, 1'b0, 1'b1);
        repeat (10) @(posedge clk);
        checking = 0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule